// File: doc/BRIEF.md
# Indirect Data Address Generator

This block turns a load or store request into an effective data-space address. The address comes either from a 16-bit absolute field or from one of three 16-bit pointers, named X, Y and Z. An indirect request can use the pointer as it is, or add a small unsigned offset to it (Y and Z only). It can also step the pointer down before the access or up after it. The pointer values are supplied from outside the block. For each pointer, a page byte can optionally be placed above it to form a wider address.

For the two stepping modes, the block returns the new pointer value together with a one-cycle write-back strobe and the code of the pointer to update. The surrounding pipeline writes that value back into its register pair. The block also classifies each address: one flag marks the register-file window, and a second flag marks the window that short I/O opcodes can reach. Every output is registered, so a request sampled on one rising edge produces its result after that edge.

Top module: `dag_top`

## Requirements
- R1: While reset is high and on the first cycle after it is released, `out_valid` and `wb_stb` are 0.
- R2: Mode code 0 (absolute) gives `out_addr` = {`direct_page`, `req_direct`} when `ext_en`=1, and {8'h00, `req_direct`} when `ext_en`=0. It produces no write-back.
- R3: Pointer code 0 selects `ptr_x`/`page_x` (the pair at register indices 27:26), code 1 selects Y (29:28) and code 2 selects Z (31:30). `wb_sel` repeats the code of the pointer being updated.
- R4: Mode code 1 (plain indirect) gives an address equal to the selected pointer and asserts no write-back.
- R5: Mode code 2 (offset) adds the zero-extended 6-bit `req_disp` to Y or Z. It asserts no write-back.
- R6: A request is rejected when it uses mode code 2 with pointer X, pointer code 3 in any indirect mode, or a mode code above 4. A rejected request leaves `out_valid` and `wb_stb` at 0.
- R7: Mode code 3 (step down) subtracts one from the pointer. It uses that value both as the address and as `wb_ptr`, and pulses `wb_stb`.
- R8: Mode code 4 (step up) addresses the unchanged pointer. It writes back the pointer plus one and pulses `wb_stb`.
- R9: With `ext_en`=0, all arithmetic wraps modulo 2^16, bits 23:16 of `out_addr` are 0, and `wb_page` returns the selected page input unchanged.
- R10: With `ext_en`=1, the page byte and the pointer form one 24-bit value. A carry or borrow crosses into the page, and the updated page appears on `wb_page`.
- R11: `in_regfile` is 1 exactly when a valid address is below 32.
- R12: `in_io` is 1 exactly when a valid address lies from 32 to 95. The two flags are never 1 together.
- R13: Results appear one clock after the request is sampled. `wb_stb` lasts one cycle per stepping request. With no valid request, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | 0 absolute, 1 plain, 2 offset, 3 step down, 4 step up |
| req_ptr_sel | input | 2 | 0 X, 1 Y, 2 Z |
| req_disp | input | 6 | Unsigned offset |
| req_direct | input | 16 | Absolute address |
| direct_page | input | 8 | Page used with absolute mode |
| ptr_x | input | 16 | X pointer value |
| ptr_y | input | 16 | Y pointer value |
| ptr_z | input | 16 | Z pointer value |
| page_x | input | 8 | Page above X |
| page_y | input | 8 | Page above Y |
| page_z | input | 8 | Page above Z |
| ext_en | input | 1 | Use the page bytes |
| out_valid | output | 1 | Address valid |
| out_addr | output | 24 | Effective address |
| in_regfile | output | 1 | Address in register-file window |
| in_io | output | 1 | Address in short I/O window |
| wb_stb | output | 1 | Pointer write-back strobe |
| wb_sel | output | 2 | Pointer to update |
| wb_ptr | output | 16 | New pointer value |
| wb_page | output | 8 | New page value |

## Verification
The assertions assume two things. Pointer and page inputs hold steady during the cycle in which a request is sampled. A new stepping request is never issued before the pipeline has consumed the previous write-back. The strobe-width property covers only cycles with no new request. The stimulus changes inputs only on falling edges. It separates back-to-back stepping requests with idle cycles wherever strobe width is checked. It deliberately sends illegal combinations, so that rejection is tested while each rejected request still leaves the outputs idle.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [2:0] {
    AM_ABS   = 3'd0,
    AM_PLAIN = 3'd1,
    AM_OFS   = 3'd2,
    AM_DEC   = 3'd3,
    AM_INC   = 3'd4
  } amode_e;

  localparam logic [1:0] PS_X = 2'd0;
  localparam logic [1:0] PS_Y = 2'd1;
  localparam logic [1:0] PS_Z = 2'd2;
endpackage

// File: rtl/dag_ptr_mux.sv
module dag_ptr_mux #(
  parameter int PTR_W = 16,
  parameter int EXT_W = 8
) (
  input  logic [1:0]       sel,
  input  logic [PTR_W-1:0] ptr_x,
  input  logic [PTR_W-1:0] ptr_y,
  input  logic [PTR_W-1:0] ptr_z,
  input  logic [EXT_W-1:0] page_x,
  input  logic [EXT_W-1:0] page_y,
  input  logic [EXT_W-1:0] page_z,
  output logic [PTR_W-1:0] ptr,
  output logic [EXT_W-1:0] page,
  output logic             sel_ok
);
  import dag_pkg::*;

  always_comb begin
    ptr    = '0;
    page   = '0;
    sel_ok = 1'b1;
    unique case (sel)
      PS_X: begin ptr = ptr_x; page = page_x; end
      PS_Y: begin ptr = ptr_y; page = page_y; end
      PS_Z: begin ptr = ptr_z; page = page_z; end
      default: sel_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/dag_arith.sv
module dag_arith #(
  parameter int PTR_W  = 16,
  parameter int EXT_W  = 8,
  parameter int DISP_W = 6
) (
  input  logic [2:0]                mode,
  input  logic [1:0]                sel,
  input  logic                      sel_ok,
  input  logic [PTR_W-1:0]          ptr,
  input  logic [EXT_W-1:0]          page,
  input  logic                      ext_en,
  input  logic [DISP_W-1:0]         disp,
  input  logic [PTR_W-1:0]          direct_addr,
  input  logic [EXT_W-1:0]          direct_page,
  output logic                      legal,
  output logic                      step,
  output logic [PTR_W+EXT_W-1:0]    addr,
  output logic [PTR_W+EXT_W-1:0]    next
);
  import dag_pkg::*;
  localparam int AW = PTR_W + EXT_W;

  logic [AW-1:0] base;
  logic [AW-1:0] dir_full;
  logic [AW-1:0] sum_ofs;
  logic [AW-1:0] sum_dec;
  logic [AW-1:0] sum_inc;

  function automatic logic [AW-1:0] fold(input logic [AW-1:0] v, input logic wide);
    return wide ? v : {{EXT_W{1'b0}}, v[PTR_W-1:0]};
  endfunction

  always_comb begin
    base     = ext_en ? {page, ptr} : {{EXT_W{1'b0}}, ptr};
    dir_full = ext_en ? {direct_page, direct_addr} : {{EXT_W{1'b0}}, direct_addr};
    sum_ofs  = fold(base + {{(AW-DISP_W){1'b0}}, disp}, ext_en);
    sum_dec  = fold(base - AW'(1), ext_en);
    sum_inc  = fold(base + AW'(1), ext_en);
  end

  always_comb begin
    legal = 1'b0;
    step  = 1'b0;
    addr  = '0;
    next  = base;
    case (mode)
      AM_ABS: begin
        legal = 1'b1;
        addr  = dir_full;
      end
      AM_PLAIN: begin
        legal = sel_ok;
        addr  = base;
      end
      AM_OFS: begin
        legal = sel_ok && (sel != PS_X);
        addr  = sum_ofs;
      end
      AM_DEC: begin
        legal = sel_ok;
        step  = 1'b1;
        addr  = sum_dec;
        next  = sum_dec;
      end
      AM_INC: begin
        legal = sel_ok;
        step  = 1'b1;
        addr  = base;
        next  = sum_inc;
      end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/dag_window.sv
module dag_window #(
  parameter int AW       = 24,
  parameter int RF_WORDS = 32,
  parameter int IO_WORDS = 64
) (
  input  logic [AW-1:0] addr,
  output logic          in_rf,
  output logic          in_io
);
  localparam logic [AW-1:0] IO_LO = AW'(RF_WORDS);
  localparam logic [AW-1:0] IO_HI = AW'(RF_WORDS + IO_WORDS);

  always_comb begin
    in_rf = addr < IO_LO;
    in_io = (addr >= IO_LO) && (addr < IO_HI);
  end
endmodule

// File: rtl/dag_top.sv
module dag_top #(
  parameter int PTR_W    = 16,
  parameter int EXT_W    = 8,
  parameter int DISP_W   = 6,
  parameter int RF_WORDS = 32,
  parameter int IO_WORDS = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [2:0]             req_mode,
  input  logic [1:0]             req_ptr_sel,
  input  logic [DISP_W-1:0]      req_disp,
  input  logic [PTR_W-1:0]       req_direct,
  input  logic [EXT_W-1:0]       direct_page,
  input  logic [PTR_W-1:0]       ptr_x,
  input  logic [PTR_W-1:0]       ptr_y,
  input  logic [PTR_W-1:0]       ptr_z,
  input  logic [EXT_W-1:0]       page_x,
  input  logic [EXT_W-1:0]       page_y,
  input  logic [EXT_W-1:0]       page_z,
  input  logic                   ext_en,
  output logic                   out_valid,
  output logic [PTR_W+EXT_W-1:0] out_addr,
  output logic                   in_regfile,
  output logic                   in_io,
  output logic                   wb_stb,
  output logic [1:0]             wb_sel,
  output logic [PTR_W-1:0]       wb_ptr,
  output logic [EXT_W-1:0]       wb_page
);
  import dag_pkg::*;
  localparam int AW = PTR_W + EXT_W;

  logic [PTR_W-1:0] sel_ptr;
  logic [EXT_W-1:0] sel_page;
  logic             sel_ok;
  logic             legal;
  logic             step;
  logic [AW-1:0]    c_addr;
  logic [AW-1:0]    c_next;
  logic             c_rf;
  logic             c_io;
  logic             ext_q;

  dag_ptr_mux #(.PTR_W(PTR_W), .EXT_W(EXT_W)) u_mux (
    .sel(req_ptr_sel), .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
    .page_x(page_x), .page_y(page_y), .page_z(page_z),
    .ptr(sel_ptr), .page(sel_page), .sel_ok(sel_ok)
  );

  dag_arith #(.PTR_W(PTR_W), .EXT_W(EXT_W), .DISP_W(DISP_W)) u_arith (
    .mode(req_mode), .sel(req_ptr_sel), .sel_ok(sel_ok), .ptr(sel_ptr),
    .page(sel_page), .ext_en(ext_en), .disp(req_disp),
    .direct_addr(req_direct), .direct_page(direct_page),
    .legal(legal), .step(step), .addr(c_addr), .next(c_next)
  );

  dag_window #(.AW(AW), .RF_WORDS(RF_WORDS), .IO_WORDS(IO_WORDS)) u_win (
    .addr(c_addr), .in_rf(c_rf), .in_io(c_io)
  );

  wire go = req_valid && legal;

  always_ff @(posedge clk) begin
    if (rst || !go) begin
      out_valid  <= 1'b0;
      out_addr   <= '0;
      in_regfile <= 1'b0;
      in_io      <= 1'b0;
      wb_stb     <= 1'b0;
      wb_sel     <= '0;
      wb_ptr     <= '0;
      wb_page    <= '0;
      ext_q      <= 1'b0;
    end else begin
      out_valid  <= 1'b1;
      out_addr   <= c_addr;
      in_regfile <= c_rf;
      in_io      <= c_io;
      wb_stb     <= step;
      wb_sel     <= step ? req_ptr_sel : 2'd0;
      wb_ptr     <= step ? c_next[PTR_W-1:0] : '0;
      wb_page    <= step ? (ext_en ? c_next[AW-1:PTR_W] : sel_page) : '0;
      ext_q      <= ext_en;
    end
  end

  AST_WB_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    wb_stb |-> out_valid); // R13
  AST_WB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (wb_stb && !req_valid) |=> !wb_stb); // R13
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(in_regfile && in_io)); // R12
  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (in_regfile || in_io) |-> out_valid); // R11
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !ext_q) |-> (out_addr[AW-1:PTR_W] == '0)); // R9
  AST_OFS_X_REJECT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == AM_OFS && req_ptr_sel == PS_X) |=> !out_valid); // R6
  AST_INC_ADDR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == AM_INC && sel_ok) |=>
      (wb_stb && out_addr[PTR_W-1:0] == $past(sel_ptr))); // R8
  AST_DEC_MATCH: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == AM_DEC && sel_ok) |=>
      (wb_stb && wb_ptr == out_addr[PTR_W-1:0])); // R7
endmodule

// File: tb/sim_dag_top.sv
module sim_dag_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10ns clk = ~clk;

  logic        req_valid = 0;
  logic [2:0]  req_mode = 0;
  logic [1:0]  req_ptr_sel = 0;
  logic [5:0]  req_disp = 0;
  logic [15:0] req_direct = 0;
  logic [7:0]  direct_page = 0;
  logic [15:0] ptr_x = 0, ptr_y = 0, ptr_z = 0;
  logic [7:0]  page_x = 0, page_y = 0, page_z = 0;
  logic        ext_en = 0;
  logic        out_valid, in_regfile, in_io, wb_stb;
  logic [23:0] out_addr;
  logic [1:0]  wb_sel;
  logic [15:0] wb_ptr;
  logic [7:0]  wb_page;

  dag_top u0 (.*);

  typedef struct {
    logic        v;
    logic [23:0] a;
    logic        rf;
    logic        io;
    logic        s;
    logic [1:0]  ws;
    logic [15:0] wp;
    logic [7:0]  wg;
    string       tag;
  } exp_t;

  exp_t q[$];
  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  function automatic exp_t model(string tag);
    exp_t e;
    logic [23:0] b, n;
    logic [15:0] p;
    logic [7:0]  g;
    logic ok;
    e = '{v:0, a:0, rf:0, io:0, s:0, ws:0, wp:0, wg:0, tag:tag};
    p = (req_ptr_sel == 0) ? ptr_x : (req_ptr_sel == 1) ? ptr_y : ptr_z;
    g = (req_ptr_sel == 0) ? page_x : (req_ptr_sel == 1) ? page_y : page_z;
    b = ext_en ? {g, p} : {8'h00, p};
    ok = req_valid && (req_mode <= 4) &&
         (req_mode == 0 || req_ptr_sel != 3) &&
         !(req_mode == 2 && req_ptr_sel == 0);
    if (!ok) return e;
    e.v = 1;
    n = b;
    case (req_mode)
      0: e.a = ext_en ? {direct_page, req_direct} : {8'h00, req_direct};
      1: e.a = b;
      2: e.a = b + 24'(req_disp);
      3: begin n = b - 1; e.a = n; end
      default: begin n = b + 1; e.a = b; end
    endcase
    if (!ext_en) begin e.a[23:16] = 0; n[23:16] = g; end
    e.rf = e.a < 32;
    e.io = e.a >= 32 && e.a < 96;
    if (req_mode >= 3) begin
      e.s = 1; e.ws = req_ptr_sel; e.wp = n[15:0]; e.wg = n[23:16];
    end
    return e;
  endfunction

  task automatic apply(input logic v, input logic [2:0] m, input logic [1:0] s,
                       input logic [5:0] d, input string tag);
    req_valid = v; req_mode = m; req_ptr_sel = s; req_disp = d;
    q.push_back(model(tag));
    @(negedge clk);
  endtask

  always begin
    @(posedge clk);
    #5ns;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      nvec++;
      if (out_valid !== e.v || out_addr !== e.a || in_regfile !== e.rf ||
          in_io !== e.io || wb_stb !== e.s || wb_sel !== e.ws ||
          wb_ptr !== e.wp || wb_page !== e.wg) begin
        nbad++;
        $display("FAIL %s: got v=%b a=%h rf=%b io=%b s=%b sel=%0d p=%h g=%h exp v=%b a=%h rf=%b io=%b s=%b sel=%0d p=%h g=%h",
          e.tag, out_valid, out_addr, in_regfile, in_io, wb_stb, wb_sel, wb_ptr, wb_page,
          e.v, e.a, e.rf, e.io, e.s, e.ws, e.wp, e.wg);
      end
    end
  end

  initial begin
    #(200000 * 20ns);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    nvec++;
    if (out_valid !== 0 || wb_stb !== 0) begin
      nbad++;
      $display("FAIL R1: got v=%b s=%b exp 0 0", out_valid, wb_stb);
    end
    rst = 0;
    nvec++;
    @(posedge clk); #5ns;
    if (out_valid !== 0 || wb_stb !== 0) begin
      nbad++;
      $display("FAIL R1: got v=%b s=%b exp 0 0 after release", out_valid, wb_stb);
    end
    @(negedge clk);
    ptr_x = 16'h0100; ptr_y = 16'h0020; ptr_z = 16'hFFFF;
    page_x = 8'h01; page_y = 8'h02; page_z = 8'h05;
    req_direct = 16'h1234; direct_page = 8'h07;
    apply(0, 3'd1, 2'd0, 0, "R13 idle");
    apply(1, 3'd0, 2'd0, 0, "R2 abs narrow");
    ext_en = 1;
    apply(1, 3'd0, 2'd3, 0, "R2 abs wide");
    ext_en = 0;
    apply(1, 3'd1, 2'd0, 0, "R3 R4 plain X");
    apply(1, 3'd1, 2'd1, 0, "R4 R12 plain Y io edge");
    apply(1, 3'd1, 2'd2, 0, "R3 plain Z");
    apply(1, 3'd2, 2'd1, 6'd63, "R5 R12 ofs Y");
    apply(1, 3'd2, 2'd2, 6'd2, "R5 R9 ofs Z wrap");
    apply(1, 3'd2, 2'd0, 6'd4, "R6 ofs X reject");
    apply(1, 3'd1, 2'd3, 0, "R6 bad pointer");
    apply(1, 3'd6, 2'd1, 0, "R6 bad mode");
    apply(1, 3'd4, 2'd0, 0, "R8 step up X");
    apply(0, 3'd0, 2'd0, 0, "R13 strobe drop");
    apply(1, 3'd3, 2'd1, 0, "R7 R11 step down Y");
    apply(0, 3'd0, 2'd0, 0, "R13 idle");
    ptr_x = 16'h0000;
    apply(1, 3'd3, 2'd0, 0, "R9 R11 dec wrap");
    apply(1, 3'd4, 2'd2, 0, "R9 inc wrap");
    ext_en = 1;
    apply(1, 3'd3, 2'd0, 0, "R10 borrow page");
    apply(1, 3'd4, 2'd2, 0, "R10 carry page");
    apply(1, 3'd2, 2'd2, 6'd1, "R10 ofs carry");
    ext_en = 0;
    ptr_y = 16'h001F;
    apply(1, 3'd1, 2'd1, 0, "R11 rf top");
    ptr_y = 16'h005F;
    apply(1, 3'd1, 2'd1, 0, "R12 io top");
    ptr_y = 16'h0060;
    apply(1, 3'd1, 2'd1, 0, "R12 above io");
    apply(0, 3'd0, 2'd0, 0, "R13 final idle");
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule